// File: doc/BRIEF.md
# Bitmap Line Address Generator

This block supplies the byte start address of each scan line of a source bitmap while a two-dimensional block transfer runs. Software presents a channel base address, a 24-bit offset to the first pixel, a 16-bit line pitch, a vertical direction bit and a line count. A one-cycle load strobe captures them. From then on, each one-cycle Y-step pulse moves the line start up or down by one pitch. The pitch is added for a top-down walk and subtracted for a bottom-up walk.

Alongside the byte address, the block keeps the other starting state the fetch logic needs. This is a start-nibble flag for 4-bpp pixel or alpha streams, and the starting X/Y position inside an 8x8 colour-pattern memory. The pattern row follows the line walk modulo 8. A line counter raises `done` once the programmed number of lines has been stepped through.

When the channel enable input is low, the generator ignores both strobes and holds every output, so the surrounding pipelines run as if the channel did not exist.

Top module: `bitmap_line_addr_gen`

## Requirements
- R1: After reset `line_addr`, `pat_x`, `pat_y`, `start_nibble`, `busy` and `done` are all 0.
- R2: A `load` pulse with `enable` high sets `line_addr` on the next cycle to `base_addr` plus the zero-extended `first_offset`, modulo 2^32.
- R3: With direction bit `y_reverse` latched as 0, each accepted Y step adds the latched zero-extended 16-bit `stride` to `line_addr`, modulo 2^32. Strides up to 65535 are supported.
- R4: With `y_reverse` latched as 1, each accepted Y step subtracts the latched stride from `line_addr`, modulo 2^32.
- R5: Stride and direction are captured only by a load. Changes on `stride` or `y_reverse` between loads have no effect on later steps.
- R6: `start_nibble` takes `nibble_sel` at load and holds it until the next load. Value 0 means the left (upper) nibble of the first byte comes first, and 1 means the right (lower) nibble.
- R7: `pat_x` and `pat_y` take `pat_x_init` and `pat_y_init` at load. Each accepted step changes `pat_y` by +1 modulo 8 in forward direction and by -1 modulo 8 in reverse. `pat_x` does not change.
- R8: A load with `line_count` N > 0 sets `busy` and clears `done`. The Nth accepted step clears `busy` and sets `done` in the same cycle. A load with N = 0 gives `busy`=0 and `done`=1 at once.
- R9: A `y_step` pulse while `busy` is 0 is ignored: all outputs are unchanged.
- R10: While `enable` is 0, both `load` and `y_step` are ignored and all outputs hold.
- R11: When `load` and `y_step` arrive in the same cycle, the load is taken and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel on; 0 freezes the generator |
| load | input | 1 | One-cycle strobe that captures the programming |
| y_step | input | 1 | One-cycle pulse that advances one line |
| base_addr | input | 32 | Channel base byte address |
| first_offset | input | 24 | Byte offset from base to the first pixel |
| stride | input | 16 | Line pitch in bytes |
| y_reverse | input | 1 | 1 = subtract the pitch on each step |
| nibble_sel | input | 1 | Starting nibble for 4-bpp data (0 left, 1 right) |
| pat_x_init | input | 3 | Starting column in the pattern memory |
| pat_y_init | input | 3 | Starting row in the pattern memory |
| line_count | input | 16 | Number of lines in the transfer |
| line_addr | output | 32 | Start byte address of the current line |
| start_nibble | output | 1 | Latched starting nibble |
| pat_x | output | 3 | Current pattern column |
| pat_y | output | 3 | Current pattern row |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | All programmed lines stepped |

## Verification
The assertions assume that `load` and `y_step` are single-cycle strobes sampled on the rising edge, and that the programming inputs are valid in the cycle of the load. They do not assume that those inputs stay steady afterwards. The stimulus drives every input half a cycle away from the rising edge. It deliberately changes `stride` and `y_reverse` during a transfer, overlaps a load with a step, and pulses both strobes with the channel disabled. It also chooses base, offset and pitch values that wrap the 32-bit address in both directions.

// File: rtl/blag_pkg.sv
package blag_pkg;
  typedef enum logic {
    YDIR_FWD = 1'b0,
    YDIR_REV = 1'b1
  } ydir_e;

  typedef enum logic {
    NIB_LEFT  = 1'b0,
    NIB_RIGHT = 1'b1
  } nib_e;
endpackage

// File: rtl/blag_addr_reg.sv
module blag_addr_reg
  import blag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFS_W   = 24,
  parameter int STRIDE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_fire,
  input  logic                step_fire,
  input  logic [ADDR_W-1:0]   base,
  input  logic [OFFS_W-1:0]   offset,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                dir_in,
  output ydir_e               dir_q,
  output logic [ADDR_W-1:0]   line_addr
);
  localparam int OFFS_PAD   = ADDR_W - OFFS_W;
  localparam int STRIDE_PAD = ADDR_W - STRIDE_W;

  logic [STRIDE_W-1:0] stride_q;

  function automatic logic [ADDR_W-1:0] first_line(
    input logic [ADDR_W-1:0] b, input logic [OFFS_W-1:0] o);
    return b + {{OFFS_PAD{1'b0}}, o};
  endfunction

  function automatic logic [ADDR_W-1:0] next_line(
    input logic [ADDR_W-1:0] cur, input logic [STRIDE_W-1:0] s, input ydir_e d);
    logic [ADDR_W-1:0] ext;
    ext = {{STRIDE_PAD{1'b0}}, s};
    return (d == YDIR_REV) ? cur - ext : cur + ext;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_addr <= '0;
      stride_q  <= '0;
      dir_q     <= YDIR_FWD;
    end else if (load_fire) begin
      line_addr <= first_line(base, offset);
      stride_q  <= stride;
      dir_q     <= ydir_e'(dir_in);
    end else if (step_fire) begin
      line_addr <= next_line(line_addr, stride_q, dir_q);
    end
  end

  // R2: load places base plus offset
  assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> line_addr == $past(base) + ADDR_W'($past(offset)));

  // R5: pitch and direction change only on a load
  assert_stride_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire |=> $stable(stride_q) && $stable(dir_q));

  // R9: no strobe, no movement
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire && !step_fire |=> $stable(line_addr));
endmodule

// File: rtl/blag_line_ctr.sv
module blag_line_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_fire,
  input  logic             step_fire,
  input  logic [CNT_W-1:0] line_count,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] lines_left;
  logic             last_line;

  assign last_line = (lines_left == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_left <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else if (load_fire) begin
      lines_left <= line_count;
      busy       <= (line_count != '0);
      done       <= (line_count == '0);
    end else if (step_fire) begin
      lines_left <= lines_left - CNT_W'(1);
      if (last_line) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R8: busy and done never together
  assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R8: final step finishes the transfer
  assert_last_step_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && last_line |=> done && !busy);

  // R8: busy implies lines remain
  assert_busy_has_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> lines_left != '0);
endmodule

// File: rtl/blag_pat_pos.sv
module blag_pat_pos
  import blag_pkg::*;
#(
  parameter int PAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_fire,
  input  logic             step_fire,
  input  ydir_e            dir_q,
  input  logic             nib_in,
  input  logic [PAT_W-1:0] x_in,
  input  logic [PAT_W-1:0] y_in,
  output nib_e             start_nibble,
  output logic [PAT_W-1:0] pat_x,
  output logic [PAT_W-1:0] pat_y
);
  function automatic logic [PAT_W-1:0] next_row(
    input logic [PAT_W-1:0] r, input ydir_e d);
    return (d == YDIR_REV) ? r - PAT_W'(1) : r + PAT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_nibble <= NIB_LEFT;
      pat_x        <= '0;
      pat_y        <= '0;
    end else if (load_fire) begin
      start_nibble <= nib_e'(nib_in);
      pat_x        <= x_in;
      pat_y        <= y_in;
    end else if (step_fire) begin
      pat_y <= next_row(pat_y, dir_q);
    end
  end

  // R7: column never moves on a step
  assert_patx_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> $stable(pat_x));

  // R6: nibble choice holds between loads
  assert_nibble_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire |=> $stable(start_nibble));

  // R7: row always moves by exactly one on a step
  assert_row_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> pat_y != $past(pat_y));
endmodule

// File: rtl/bitmap_line_addr_gen.sv
module bitmap_line_addr_gen
  import blag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFS_W   = 24,
  parameter int STRIDE_W = 16,
  parameter int PAT_W    = 3,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                load,
  input  logic                y_step,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [OFFS_W-1:0]   first_offset,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                y_reverse,
  input  logic                nibble_sel,
  input  logic [PAT_W-1:0]    pat_x_init,
  input  logic [PAT_W-1:0]    pat_y_init,
  input  logic [CNT_W-1:0]    line_count,
  output logic [ADDR_W-1:0]   line_addr,
  output logic                start_nibble,
  output logic [PAT_W-1:0]    pat_x,
  output logic [PAT_W-1:0]    pat_y,
  output logic                busy,
  output logic                done
);
  logic  load_fire;
  logic  step_fire;
  ydir_e dir_q;
  nib_e  nib_q;

  assign load_fire    = enable && load;
  assign step_fire    = enable && y_step && busy && !load;
  assign start_nibble = nib_q;

  blag_addr_reg #(
    .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .STRIDE_W(STRIDE_W)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .load_fire(load_fire), .step_fire(step_fire),
    .base(base_addr), .offset(first_offset), .stride(stride),
    .dir_in(y_reverse), .dir_q(dir_q), .line_addr(line_addr)
  );

  blag_line_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load_fire(load_fire), .step_fire(step_fire),
    .line_count(line_count), .busy(busy), .done(done)
  );

  blag_pat_pos #(.PAT_W(PAT_W)) u_pat (
    .clk(clk), .rst_n(rst_n), .load_fire(load_fire), .step_fire(step_fire),
    .dir_q(dir_q), .nib_in(nibble_sel), .x_in(pat_x_init), .y_in(pat_y_init),
    .start_nibble(nib_q), .pat_x(pat_x), .pat_y(pat_y)
  );

  // R10: disabled channel freezes every output
  assert_disabled_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(line_addr) && $stable(busy) && $stable(done) && $stable(pat_y));

  // R11: a load in the same cycle as a step wins
  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    enable && load && y_step |=> line_addr == $past(base_addr) + ADDR_W'($past(first_offset)));
endmodule

// File: tb/tb_bitmap_line_addr_gen.sv
`timescale 1ns/1ps
module tb_bitmap_line_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, load = 1'b0, y_step = 1'b0;
  logic [31:0] base_addr = '0;
  logic [23:0] first_offset = '0;
  logic [15:0] stride = '0;
  logic        y_reverse = 1'b0, nibble_sel = 1'b0;
  logic [2:0]  pat_x_init = '0, pat_y_init = '0;
  logic [15:0] line_count = '0;
  logic [31:0] line_addr;
  logic        start_nibble, busy, done;
  logic [2:0]  pat_x, pat_y;

  int total = 0, bad = 0, cycles = 0;
  string tag = "R1";

  bit [31:0] m_addr; bit [15:0] m_stride; bit m_rev, m_nib, m_busy, m_done;
  int m_px, m_py, m_left;

  always #2.5 clk = ~clk;

  bitmap_line_addr_gen dut (.*);

  // behavioural reference, updated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr = 0; m_stride = 0; m_rev = 0; m_nib = 0; m_busy = 0; m_done = 0;
      m_px = 0; m_py = 0; m_left = 0;
    end else if (enable && load) begin
      m_addr = base_addr + 32'(first_offset);
      m_stride = stride; m_rev = y_reverse; m_nib = nibble_sel;
      m_px = pat_x_init; m_py = pat_y_init; m_left = line_count;
      m_busy = (line_count != 0); m_done = (line_count == 0);
    end else if (enable && y_step && m_busy) begin
      if (m_rev) begin m_addr = m_addr - 32'(m_stride); m_py = (m_py + 7) % 8; end
      else       begin m_addr = m_addr + 32'(m_stride); m_py = (m_py + 1) % 8; end
      m_left = m_left - 1;
      if (m_left == 0) begin m_busy = 0; m_done = 1; end
    end
  end

  task automatic chk(input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("line_addr", line_addr, m_addr);
      chk("start_nibble", start_nibble, m_nib);
      chk("pat_x", pat_x, m_px);
      chk("pat_y", pat_y, m_py);
      chk("busy", busy, m_busy);
      chk("done", done, m_done);
    end
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_load(input logic [31:0] b, input logic [23:0] o, input logic [15:0] s,
                         input logic r, input logic n, input logic [2:0] x, input logic [2:0] y,
                         input logic [15:0] c);
    base_addr = b; first_offset = o; stride = s; y_reverse = r; nibble_sel = n;
    pat_x_init = x; pat_y_init = y; line_count = c; load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      y_step = 1'b1; @(negedge clk); y_step = 1'b0; @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("reset addr R1", line_addr, 0);
    chk("reset busy R1", busy, 0);
    rst_n = 1'b1; enable = 1'b1;
    @(negedge clk);

    tag = "R2";
    do_load(32'h0000_1000, 24'h20, 16'd640, 1'b0, 1'b0, 3'd2, 3'd6, 16'd5);
    chk("first line R2", line_addr, 32'h1020);
    tag = "R6"; chk("nibble left R6", start_nibble, 0);
    tag = "R3"; steps(3);
    chk("three steps R3", line_addr, 32'h1020 + 3 * 640);
    tag = "R7"; chk("pat_y wrap R7", pat_y, 1);
    chk("pat_x fixed R7", pat_x, 2);
    tag = "R5"; stride = 16'd7; y_reverse = 1'b1; steps(2);
    chk("latched pitch R5", line_addr, 32'h1020 + 5 * 640);
    tag = "R8"; chk("done after N R8", done, 1);
    chk("busy low R8", busy, 0);
    tag = "R9"; steps(2);
    chk("step ignored R9", line_addr, 32'h1020 + 5 * 640);

    tag = "R4";
    do_load(32'h0000_0100, 24'h0, 16'h0300, 1'b1, 1'b1, 3'd0, 3'd1, 16'd4);
    tag = "R6"; chk("nibble right R6", start_nibble, 1);
    tag = "R4"; steps(1);
    chk("reverse wrap R4", line_addr, 32'hFFFF_FE00);
    steps(2);
    tag = "R7"; chk("pat_y reverse R7", pat_y, 6);

    tag = "R3";
    do_load(32'hFFFF_FF00, 24'hFF_FFFF, 16'hFFFF, 1'b0, 1'b0, 3'd7, 3'd7, 16'd3);
    tag = "R2"; chk("offset wrap R2", line_addr, 32'h00FF_FEFF);
    tag = "R3"; steps(3);
    chk("max stride R3", line_addr, 32'h00FF_FEFF + 3 * 32'hFFFF);

    tag = "R10";
    do_load(32'h4000, 24'h10, 16'd100, 1'b0, 1'b0, 3'd1, 3'd1, 16'd10);
    enable = 1'b0;
    do_load(32'h9999_0000, 24'h5, 16'd1, 1'b1, 1'b1, 3'd3, 3'd3, 16'd2);
    steps(2);
    chk("disabled hold R10", line_addr, 32'h4010);
    chk("disabled busy R10", busy, 1);
    enable = 1'b1;

    tag = "R11";
    y_step = 1'b1;
    do_load(32'h5000, 24'h4, 16'd8, 1'b0, 1'b0, 3'd0, 3'd0, 16'd2);
    y_step = 1'b0;
    chk("load beats step R11", line_addr, 32'h5004);
    chk("row not stepped R11", pat_y, 0);

    tag = "R8";
    do_load(32'h6000, 24'h0, 16'd4, 1'b0, 1'b0, 3'd0, 3'd0, 16'd0);
    chk("zero lines done R8", done, 1);
    chk("zero lines busy R8", busy, 0);
    steps(1);
    chk("zero lines no step R8", line_addr, 32'h6000);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule